// File: doc/BRIEF.md
# Odd-Up Even-Down Sequence Counter

This block is a synchronous counter whose output does not follow binary order. Starting from 1, it climbs through every odd code up to the all-ones value. It then turns down to the largest even code and falls by two each step to 0. From 0 it wraps to 1 and repeats. With the default 4-bit width the cycle is 1, 3, 5, 7, 9, 11, 13, 15, 14, 12, 10, 8, 6, 4, 2, 0. All sixteen codes appear once, so there are no unused states.

The state is held in D flip-flops with an enable, one per bit. When the count enable is low, every bit keeps its value. A synchronous active-high reset loads the first value of the cycle. A parameter selects how the next-state function is built: as add/subtract arithmetic, or as a lookup table computed at elaboration time. Both give the same sequence.

Top module: `zigzag_counter`

## Requirements
- R1: When reset is high at a rising clock edge, the output is 1 after that edge, whatever the enable is.
- R2: With enable high, an odd output below the all-ones value is followed by that value plus 2 at the next edge.
- R3: With enable high, the all-ones value (15 at the default width) is followed by all-ones minus 1 (14).
- R4: With enable high, a nonzero even output is followed by that value minus 2 at the next edge.
- R5: With enable high, an output of 0 is followed by 1.
- R6: With enable low and reset low, the output at the next edge equals its present value.
- R7: With enable held high from reset, the output visits all 2^WIDTH codes once in every 2^WIDTH cycles, and the list repeats unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; loads 1 |
| en | input | 1 | Count enable; low holds every bit |
| value | output | WIDTH | Present sequence value |

## Verification
The hardest case to reach is a hold that falls exactly on a turning point: enable low while the output sits at the all-ones value or at 0. If the hold logic were wired in only part of the bits, that is where it would show. A stretch of random enable patterns cannot be relied on to land there. So the stimulus first runs two full enabled laps and then adds holds on purpose at 15 and at 0. After that come random enable-low cycles and a reset in the middle of the sequence with enable low. A behavioural queue model is compared with the output on every cycle.

// File: rtl/zz_pkg.sv
package zz_pkg;

   // How the next-state function is built
   typedef enum logic {
      NEXT_ARITH = 1'b0,
      NEXT_TABLE = 1'b1
   } zz_style_e;

endpackage

// File: rtl/zz_next.sv
module zz_next #(
   parameter int unsigned      WIDTH = 4,
   parameter zz_pkg::zz_style_e STYLE = zz_pkg::NEXT_ARITH
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);
   localparam int unsigned            CODES = 2 ** WIDTH;
   localparam logic [WIDTH-1:0]       TOP   = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0]       STEP  = WIDTH'(2);
   localparam logic [WIDTH-1:0]       ONE   = WIDTH'(1);

   function automatic logic [WIDTH-1:0] succ(input int unsigned c);
      int unsigned r;
      if (c == CODES - 1)  r = CODES - 2;
      else if (c == 0)     r = 1;
      else if (c % 2 == 1) r = c + 2;
      else                 r = c - 2;
      return WIDTH'(r);
   endfunction

   generate
      if (STYLE == zz_pkg::NEXT_TABLE) begin : g_table
         logic [WIDTH-1:0] lut [CODES];
         for (genvar g = 0; g < CODES; g++) begin : g_ent
            assign lut[g] = succ(g);
         end
         assign nxt = lut[cur];
      end else begin : g_arith
         always_comb begin
            if (cur == TOP)             nxt = TOP - ONE;
            else if (cur == '0)         nxt = ONE;
            else if (cur[0])            nxt = cur + STEP;
            else                        nxt = cur - STEP;
         end
      end
   endgenerate
endmodule

// File: rtl/zz_dffe.sv
module zz_dffe #(
   parameter int unsigned      WIDTH = 4,
   parameter logic [WIDTH-1:0] INIT  = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         always_ff @(posedge clk) begin
            if (rst)     q[b] <= INIT[b];
            else if (en) q[b] <= d[b];
         end
      end
   endgenerate
endmodule

// File: rtl/zigzag_counter.sv
module zigzag_counter #(
   parameter int unsigned       WIDTH = 4,
   parameter zz_pkg::zz_style_e STYLE = zz_pkg::NEXT_ARITH
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic [WIDTH-1:0] value
);
   localparam logic [WIDTH-1:0] FIRST = WIDTH'(1);
   localparam logic [WIDTH-1:0] TOP   = {WIDTH{1'b1}};

   generate
      if (WIDTH < 2 || WIDTH > 12) begin : g_bad_width
         $error("zigzag_counter: WIDTH must lie in 2..12");
      end
   endgenerate

   logic [WIDTH-1:0] nxt;

   zz_next #(.WIDTH(WIDTH), .STYLE(STYLE)) u_next (
      .cur (value),
      .nxt (nxt)
   );

   zz_dffe #(.WIDTH(WIDTH), .INIT(FIRST)) u_state (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .d   (nxt),
      .q   (value)
   );

   // R1
   reset_load_chk: assert property (@(posedge clk) rst |=> value == FIRST);
   // R2
   odd_climb_chk: assert property (@(posedge clk) disable iff (rst)
      (en && value[0] && value != TOP) |=> value == $past(value) + WIDTH'(2));
   // R3
   peak_turn_chk: assert property (@(posedge clk) disable iff (rst)
      (en && value == TOP) |=> value == TOP - WIDTH'(1));
   // R4
   even_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (en && !value[0] && value != '0) |=> value == $past(value) - WIDTH'(2));
   // R5
   wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (en && value == '0) |=> value == FIRST);
   // R6
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(value));
endmodule

// File: tb/test_zigzag_counter.sv
module test_zigzag_counter;
   localparam int W = 4;
   localparam int N = 2 ** W;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en  = 1'b0;
   logic [W-1:0] value;

   int vectors = 0;
   int errors  = 0;
   int order[$];
   int pos = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   zigzag_counter #(.WIDTH(W)) i_zigzag_counter (
      .clk(clk), .rst(rst), .en(en), .value(value)
   );

   task automatic check(input string req);
      vectors++;
      if (int'(value) !== order[pos]) begin
         errors++;
         $display("FAIL %s: value=%0d expected=%0d at %0t", req, value, order[pos], $time);
      end
   endtask

   // drive at negedge, clock, then compare at the following negedge
   task automatic step(input bit r, input bit e, input string req);
      rst = r; en = e;
      @(posedge clk);
      if (r) pos = 0;
      else if (e) pos = (pos + 1) % N;
      @(negedge clk);
      check(req);
   endtask

   initial begin
      for (int v = 1; v < N; v += 2) order.push_back(v);
      for (int v = N - 2; v >= 0; v -= 2) order.push_back(v);

      @(negedge clk);
      step(1'b1, 1'b1, "R1");                   // reset with enable high
      step(1'b1, 1'b0, "R1");
      // two full laps: R2 R3 R4 R5 R7
      for (int i = 0; i < 2 * N; i++) begin
         if (order[pos] == N - 1)  step(1'b0, 1'b1, "R3");
         else if (order[pos] == 0) step(1'b0, 1'b1, "R5");
         else if (order[pos] % 2)  step(1'b0, 1'b1, "R2");
         else                      step(1'b0, 1'b1, "R4/R7");
      end
      // hold exactly at the turning points
      while (order[pos] != N - 1) step(1'b0, 1'b1, "R2");
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R6");
      step(1'b0, 1'b1, "R3");
      while (order[pos] != 0) step(1'b0, 1'b1, "R4");
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R6");
      step(1'b0, 1'b1, "R5");
      // random enable-low cycles
      for (int i = 0; i < 200; i++) begin
         bit e;
         e = ($urandom_range(0, 3) != 0);
         step(1'b0, e, e ? "R2/R4" : "R6");
      end
      // reset mid-sequence with enable low
      while (order[pos] != 10) step(1'b0, 1'b1, "R4");
      step(1'b1, 1'b0, "R1");
      step(1'b0, 1'b1, "R2");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: value=%0d expected=progress", value);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule